// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the execution half of a microprogrammed machine. Every clock cycle it takes a 16-bit command word and carries out one register transfer. The word holds a separate small field for each unit: an operand-source selector, an ALU operation, a shifter operation and a result destination. The operand source is one of eight registers or the external input port. The ALU always takes the accumulator as its first operand and the selected source as its second. The shifter post-processes the ALU result. The shifter output is then written into one register, into the accumulator, or nowhere.

Two condition flags, zero and carry, are captured from the shifter output of every command and returned to the sequencer. Zero is set when that output is all zeros, and carry is its most significant bit. A subtraction passed straight through the shifter therefore puts the sign of the difference on the carry flag, which gives the sequencer a less-than test. Sequencing of the control store is not part of this block. Any field value that has no assigned meaning is harmless: it can never change the register file or the accumulator by accident.

Command word layout, most significant bit first: bits 15:12 source select, bits 11:8 ALU operation, bits 7:5 shifter operation, bits 4:1 destination, and bit 0 spare (ignored). The word that copies R2 into the accumulator is 16'h21F0.

Top module: `ucode_datapath`

## Requirements
- R1: While rst is high at a clock edge, the accumulator, zero flag and carry flag are cleared to 0 at that edge.
- R2: Source codes 0000 to 0111 place register R0 to R7 on the source bus, code 1000 places in_port_i there, and codes 1001 to 1111 place zero there.
- R3: ALU codes are: 0000 zero, 0001 pass source, 0010 ACC+source, 0011 source−ACC, 0100 ACC−source, 0101 AND, 0110 OR, 0111 XOR, 1000 pass ACC, 1001 inverted source, 1010 source+1, 1011 source−1. Codes 1100 to 1111 give zero. All arithmetic is modulo 2^DATA_W.
- R4: Shifter codes are: 000 shift left by one with a 0 entering, 001 logical shift right by one, 010 rotate left, 011 rotate right, 100 arithmetic shift right. Codes 101, 110 and 111 pass the value unchanged.
- R5: Destination codes 0000 to 0111 write the shifter output into R0 to R7, and code 1000 writes it into the accumulator. The write takes effect at the clock edge that ends the command.
- R6: Destination codes 1001 to 1111 write nothing. The accumulator and all registers keep their values, and the spare bit 0 has no effect.
- R7: After each command, zero_o is 1 exactly when that command's shifter output was all zeros.
- R8: After each command, carry_o equals the most significant bit of that command's shifter output. With ALU code 0100 and shifter code 111, carry_o is 1 when ACC is less than the source for operands below 2^(DATA_W−1).
- R9: One command completes per cycle. A register written by one command is read correctly by the command in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 16 | Command word for this cycle |
| in_port_i | input | DATA_W | External data input, selectable as the source operand |
| acc_o | output | DATA_W | Accumulator contents (registered) |
| zero_o | output | 1 | Zero flag from the previous command's shifter output |
| carry_o | output | 1 | Most significant bit of the previous command's shifter output |

## Verification
The bench drives long back-to-back command streams. It stresses a register being written and read in adjacent cycles: a design with a stale read path would return the old register value. It drives every unused destination code and then reads every register back through the accumulator. A decoder that folds those codes onto a real register would show up as a corrupted register or accumulator. It also exercises the unused source codes and the equal-operand subtraction that must raise the zero flag. It covers the less-than subtraction, which catches a carry flag taken from the wrong bit or from the ALU instead of the shifter. It runs all five shift kinds on a pattern with both end bits set, which exposes a swapped rotate or a right shift that loses the sign bit.

// File: rtl/ucdp_pkg.sv
package ucdp_pkg;

  localparam int SRC_W = 4;
  localparam int ALU_W = 4;
  localparam int SHF_W = 3;
  localparam int DST_W = 4;
  localparam int CMD_W = SRC_W + ALU_W + SHF_W + DST_W + 1;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [ALU_W-1:0] alu;
    logic [SHF_W-1:0] shf;
    logic [DST_W-1:0] dst;
    logic             spare;
  } cmd_t;

  typedef enum logic [ALU_W-1:0] {
    ALU_ZERO = 4'd0,
    ALU_PASS = 4'd1,
    ALU_ADD  = 4'd2,
    ALU_RSUB = 4'd3,
    ALU_SUB  = 4'd4,
    ALU_AND  = 4'd5,
    ALU_OR   = 4'd6,
    ALU_XOR  = 4'd7,
    ALU_ACC  = 4'd8,
    ALU_NOT  = 4'd9,
    ALU_INC  = 4'd10,
    ALU_DEC  = 4'd11
  } alu_op_e;

  typedef enum logic [SHF_W-1:0] {
    SH_SHL  = 3'd0,
    SH_SHR  = 3'd1,
    SH_ROL  = 3'd2,
    SH_ROR  = 3'd3,
    SH_ASR  = 3'd4,
    SH_PASS = 3'd7
  } shf_op_e;

endpackage

// File: rtl/ucdp_regfile.sv
module ucdp_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5
  rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ucdp_alu.sv
module ucdp_alu
  import ucdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ALU_W-1:0]  op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] y
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      ALU_ZERO: y = '0;
      ALU_PASS: y = opnd;
      ALU_ADD:  y = acc + opnd;
      ALU_RSUB: y = opnd - acc;
      ALU_SUB:  y = acc - opnd;
      ALU_AND:  y = acc & opnd;
      ALU_OR:   y = acc | opnd;
      ALU_XOR:  y = acc ^ opnd;
      ALU_ACC:  y = acc;
      ALU_NOT:  y = ~opnd;
      ALU_INC:  y = opnd + ONE;
      ALU_DEC:  y = opnd - ONE;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/ucdp_shift.sv
module ucdp_shift
  import ucdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SHF_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      SH_SHL:  y = {a[DATA_W-2:0], 1'b0};
      SH_SHR:  y = {1'b0, a[DATA_W-1:1]};
      SH_ROL:  y = {a[DATA_W-2:0], a[DATA_W-1]};
      SH_ROR:  y = {a[0], a[DATA_W-1:1]};
      SH_ASR:  y = {a[DATA_W-1], a[DATA_W-1:1]};
      default: y = a;
    endcase
  end

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import ucdp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] in_port_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              carry_o
);

  localparam int             RA_W    = $clog2(NUM_REGS);
  localparam logic [SRC_W-1:0] SRC_IN  = SRC_W'(NUM_REGS);
  localparam logic [DST_W-1:0] DST_ACC = DST_W'(NUM_REGS);

  cmd_t              cmd;
  logic [DATA_W-1:0] rf_rd;
  logic [DATA_W-1:0] sbus;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] sh_y;
  logic [DATA_W-1:0] acc_q;
  logic              z_q;
  logic              c_q;
  logic              rf_we;
  logic              acc_we;
  logic              unused_spare;

  assign cmd          = cmd_t'(cmd_i);
  assign unused_spare = cmd.spare;

  // operand source selection
  always_comb begin
    if (cmd.src < SRC_IN) begin
      sbus = rf_rd;
    end else if (cmd.src == SRC_IN) begin
      sbus = in_port_i;
    end else begin
      sbus = '0;
    end
  end

  // destination decode
  assign rf_we  = !rst && (cmd.dst < DST_ACC);
  assign acc_we = (cmd.dst == DST_ACC);

  ucdp_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (cmd.dst[RA_W-1:0]),
    .wdata (sh_y),
    .raddr (cmd.src[RA_W-1:0]),
    .rdata (rf_rd)
  );

  ucdp_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (cmd.alu),
    .acc  (acc_q),
    .opnd (sbus),
    .y    (alu_y)
  );

  ucdp_shift #(.DATA_W(DATA_W)) u_shf (
    .op (cmd.shf),
    .a  (alu_y),
    .y  (sh_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      if (acc_we) begin
        acc_q <= sh_y;
      end
      z_q <= ~|sh_y;
      c_q <= sh_y[DATA_W-1];
    end
  end

  assign acc_o   = acc_q;
  assign zero_o  = z_q;
  assign carry_o = c_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !z_q && !c_q));

  // R6
  idle_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.dst != DST_ACC) |=> $stable(acc_q));

  // R5
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.dst == DST_ACC) |=> (acc_q == $past(sh_y)));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    z_q |-> !c_q);

endmodule

// File: tb/tb_ucode_datapath.sv
module tb_ucode_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cmd = {4'b1001, 4'b0000, 3'b111, 4'b1111, 1'b0};
  logic [7:0]  in_port = 8'h00;
  logic [7:0]  acc_o;
  logic        zero_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_rf [8];
  logic [7:0] m_acc = 8'h00;

  logic [7:0] q_acc [$];
  logic       q_z   [$];
  logic       q_c   [$];
  string      q_tag [$];

  always #10 clk = ~clk;

  ucode_datapath dut (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd),
    .in_port_i (in_port),
    .acc_o     (acc_o),
    .zero_o    (zero_o),
    .carry_o   (carry_o)
  );

  function automatic logic [7:0] m_alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] s);
    case (op)
      4'd0:    return 8'h00;
      4'd1:    return s;
      4'd2:    return a + s;
      4'd3:    return s - a;
      4'd4:    return a - s;
      4'd5:    return a & s;
      4'd6:    return a | s;
      4'd7:    return a ^ s;
      4'd8:    return a;
      4'd9:    return ~s;
      4'd10:   return s + 8'd1;
      4'd11:   return s - 8'd1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_shift(input logic [2:0] op, input logic [7:0] x);
    case (op)
      3'd0:    return {x[6:0], 1'b0};
      3'd1:    return {1'b0, x[7:1]};
      3'd2:    return {x[6:0], x[7]};
      3'd3:    return {x[0], x[7:1]};
      3'd4:    return {x[7], x[7:1]};
      default: return x;
    endcase
  endfunction

  // driver: applies one command word and pushes the expected outcome
  task automatic issue_raw(input logic [15:0] w, input logic [7:0] din, input string tag);
    logic [7:0] sb;
    logic [7:0] r;
    @(negedge clk);
    cmd     = w;
    in_port = din;
    if (w[15:12] < 4'd8)       sb = m_rf[w[14:12]];
    else if (w[15:12] == 4'd8) sb = din;
    else                       sb = 8'h00;
    r = m_shift(w[7:5], m_alu(w[11:8], m_acc, sb));
    if (w[4:1] < 4'd8)       m_rf[w[3:1]] = r;
    else if (w[4:1] == 4'd8) m_acc = r;
    q_acc.push_back(m_acc);
    q_z.push_back(r == 8'h00);
    q_c.push_back(r[7]);
    q_tag.push_back(tag);
  endtask

  task automatic issue(input logic [3:0] src, input logic [3:0] alu, input logic [2:0] shf,
                       input logic [3:0] dst, input logic [7:0] din, input string tag);
    issue_raw({src, alu, shf, dst, 1'b0}, din, tag);
  endtask

  // monitor: pops one expected item per executed command
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_acc.size() > 0) begin
        logic [7:0] ea;
        logic       ez;
        logic       ec;
        string      t;
        ea = q_acc.pop_front();
        ez = q_z.pop_front();
        ec = q_c.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (acc_o !== ea || zero_o !== ez || carry_o !== ec) begin
          errors++;
          $display("FAIL %s: acc=%h z=%b c=%b expected acc=%h z=%b c=%b",
                   t, acc_o, zero_o, carry_o, ea, ez, ec);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (acc_o !== 8'h00 || zero_o !== 1'b0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: acc=%h z=%b c=%b expected acc=00 z=0 c=0", acc_o, zero_o, carry_o);
    end

    // R5 R2: load every register from the input port
    for (int i = 0; i < 8; i++) begin
      issue(4'b1000, 4'b0001, 3'b111, 4'(i), 8'(8'h10 + i), "R5 write reg from input");
    end
    issue(4'b1000, 4'b0001, 3'b111, 4'b0010, 8'h2A, "R2 input port into R2");
    issue_raw(16'h21F0, 8'h00, "R2 R5 copy R2 into ACC");
    issue(4'b1000, 4'b0001, 3'b111, 4'b1000, 8'h05, "R2 input into ACC");
    issue(4'b1000, 4'b0001, 3'b111, 4'b0001, 8'h09, "R5 input into R1");
    // R8: less-than through ACC - source
    issue(4'b0001, 4'b0100, 3'b111, 4'b1111, 8'h00, "R8 ACC<R1 sets carry");
    issue(4'b0001, 4'b0011, 3'b111, 4'b1111, 8'h00, "R8 R1-ACC clears carry");
    // R3: ALU functions
    issue(4'b0001, 4'b0010, 3'b111, 4'b1000, 8'h00, "R3 add");
    issue(4'b1000, 4'b0101, 3'b111, 4'b1000, 8'h3C, "R3 and");
    issue(4'b1000, 4'b0110, 3'b111, 4'b1000, 8'hA1, "R3 or");
    issue(4'b1000, 4'b0111, 3'b111, 4'b1000, 8'hFF, "R3 xor");
    issue(4'b1000, 4'b1001, 3'b111, 4'b0100, 8'h0F, "R3 invert source into R4");
    issue(4'b0100, 4'b1010, 3'b111, 4'b1000, 8'h00, "R3 R9 increment R4 next cycle");
    issue(4'b1000, 4'b1011, 3'b111, 4'b1000, 8'h00, "R3 decrement wraps");
    issue(4'b0000, 4'b1000, 3'b111, 4'b0101, 8'h00, "R3 pass ACC into R5");
    issue(4'b0000, 4'b1100, 3'b111, 4'b1000, 8'h77, "R3 R7 unused ALU code gives zero");
    // R4: shifter kinds on a pattern with both end bits set
    for (int k = 0; k < 8; k++) begin
      issue(4'b1000, 4'b0001, 3'(k), 4'b1000, 8'h81, "R4 shift kind");
    end
    // R2 R7: unused source codes drive zero
    issue(4'b1011, 4'b0001, 3'b111, 4'b1000, 8'h55, "R2 R7 unused source is zero");
    // R7: equal operands give zero flag
    issue(4'b1000, 4'b0001, 3'b111, 4'b1000, 8'h33, "R2 load ACC");
    issue(4'b1000, 4'b0100, 3'b111, 4'b1111, 8'h33, "R7 equal subtract sets zero");
    // R6: unused destination codes and spare bit
    for (int d = 9; d < 16; d++) begin
      issue(4'b1000, 4'b0001, 3'b111, 4'(d), 8'hE7, "R6 unused destination writes nothing");
    end
    issue_raw({4'b1000, 4'b0001, 3'b111, 4'b1111, 1'b1}, 8'h99, "R6 spare bit ignored");
    // R9: back-to-back write then read
    issue(4'b1000, 4'b0001, 3'b111, 4'b0011, 8'hC4, "R9 write R3");
    issue(4'b0011, 4'b0001, 3'b111, 4'b1000, 8'h00, "R9 read R3 next cycle");
    // R6 R5: read back every register
    for (int i = 0; i < 8; i++) begin
      issue(4'(i), 4'b0001, 3'b111, 4'b1000, 8'h00, "R6 R5 register readback");
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule